// File: doc/BRIEF.md
# Digital Black-Level Clamp Controller

This block closes a digital feedback loop around the optical-black level of an image sensor's converted pixel stream. A window pulse marks the black pixels at the start of each line. The block averages a small group of those pixels and forms an error against a programmable target. It then adds a scaled copy of that error into a fixed-point correction accumulator. The integer part of the accumulator is presented as a signed offset word, which the datapath downstream adds to the pixels.

The loop gain is a power-of-two fraction of the error. It has a normal setting and a fast-acquisition setting that is larger by a selectable factor. A strobe that reports a change in amplifier gain forces the fast setting. Fast mode stays on while the black-level error is large. Once the error is small, it stays on for a chosen number of further lines and then ends. When wide-window handling is enabled and a window stays active long enough, the block stops averaging for that line and corrects on every clock, using each pixel as it arrives.

Top module: `blc_loop`

## Requirements
- R1: While rst_n is low at a rising clock edge, the accumulator, the hold-line counter and the window counters are cleared. After that edge corr_o = 0, fast_o = 0 and wide_o = 0.
- R2: The window is active when win_i equals win_pol_i: 1 means active-high and 0 means active-low. A line ends on the first clock at which the window is inactive after having been active, and any per-line update is applied at that clock's edge.
- R3: During the active window, the first 8 pixels (avg_sel_i = 0) or the first 4 pixels (avg_sel_i = 1) are summed, and the average is the sum shifted right by 3 or by 2. A window that has fewer active clocks than that count produces no update and does not count toward the hold lines.
- R4: The error is target_i minus the average, or minus the pixel itself in a wide window. It is clamped to ±ERR_MAX (default 255) before the gain is applied.
- R5: The accumulator has 8 fractional bits. In normal mode it gains (error × 2^8) >> 8, which is the error in units of 1/256 LSB. corr_o is the accumulator shifted right arithmetically by 8, so it rounds toward minus infinity. The accumulator saturates at its signed range, giving corr_o = 8191 at most.
- R6: In fast mode the step is multiplied by 2^(fast_sel_i + 2): code 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32.
- R7: A high gain_chg_i at a clock edge sets fast_o after that edge and restarts the hold-line count. This takes priority over any line-end decision on the same edge.
- R8: While fast, each line with an update whose unclamped error magnitude exceeds 32 restarts the hold count. fast_o falls at the end of the (hold_sel_i + 1)-th consecutive line whose error magnitude is 32 or less.
- R9: With wide_en_i = 1, once 63 active clocks have passed in the current window, wide_o is high. Every further active clock then applies a step using target_i minus pix_i, and the averaged update at the end of that window is skipped.
- R10: At the end of a wide window, fast-mode line accounting uses the error of the last per-clock update of that window.
- R11: With wide_en_i = 0, a long window never raises wide_o and gets the single averaged update of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_i | input | 1 | Optical-black window pulse |
| win_pol_i | input | 1 | Window polarity, 1 = active-high |
| pix_i | input | DW | Unsigned pixel word |
| gain_chg_i | input | 1 | Amplifier gain changed strobe |
| target_i | input | DW | Target black level |
| avg_sel_i | input | 1 | 0 = average 8 pixels, 1 = average 4 |
| fast_sel_i | input | 2 | Fast factor code, 2^(code+2) |
| hold_sel_i | input | 2 | Extra fast lines minus one |
| wide_en_i | input | 1 | Enable wide-window per-clock correction |
| corr_o | output | CW | Signed offset correction, integer part |
| fast_o | output | 1 | Fast acquisition active |
| wide_o | output | 1 | Current window judged wide |

## Verification
corr_o and fast_o are registered. They change on the rising edge that samples the first inactive window clock, or on the edge that samples a wide-window active clock. wide_o rises on the edge that samples the 63rd active clock and also follows wide_en_i combinationally. The bench drives every input just after a falling edge. One time unit later it compares all three outputs against a reference model, and only then advances the model by the coming rising edge, so each comparison sees exactly the edges the requirements count. Directed sequences add fixed expected values for clamping, averaging, hold counts, the wide window and saturation.

// File: rtl/blc_pkg.sv
// Shared types for the black-level clamp loop.
// Assumes nothing beyond IEEE 1800-2017 packages.
package blc_pkg;
    // Loop-gain regime of the clamp controller
    typedef enum logic {
        BLC_NORMAL = 1'b0,
        BLC_FAST   = 1'b1
    } blc_mode_e;
endpackage

// File: rtl/blc_window.sv
// Window front end: applies the polarity, counts active clocks, sums the
// first pixels of the window and flags the line end and the wide-window state.
// Assumes the window pulse is already synchronous to clk.
module blc_window #(
    parameter int DW       = 12,
    parameter int AVG_LOG2 = 3,
    parameter int WIDE_LEN = 63,
    localparam int AW      = DW + AVG_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_i,
    input  logic          win_pol_i,
    input  logic [DW-1:0] pix_i,
    input  logic          avg_sel_i,
    input  logic          wide_en_i,
    output logic          act_o,
    output logic          line_end_o,
    output logic          wide_o,
    output logic          avg_rdy_o,
    output logic [AW-1:0] avg_o
);
    localparam int WW = $clog2(WIDE_LEN + 1);
    localparam int PW = AVG_LOG2 + 1;

    logic          act_q;
    logic [WW-1:0] wcnt_q;
    logic [PW-1:0] pcnt_q;
    logic [AW-1:0] sum_q;
    logic [PW-1:0] n_need;

    assign act_o      = win_pol_i ? win_i : ~win_i;
    assign n_need     = avg_sel_i ? PW'(1 << (AVG_LOG2 - 1)) : PW'(1 << AVG_LOG2);
    assign line_end_o = act_q & ~act_o;
    assign wide_o     = wide_en_i & (wcnt_q == WW'(WIDE_LEN));
    assign avg_rdy_o  = line_end_o & ~wide_o & (pcnt_q == n_need);
    assign avg_o      = avg_sel_i ? (sum_q >> (AVG_LOG2 - 1)) : (sum_q >> AVG_LOG2);

    // Track window phase, width and the running pixel sum of this window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            wcnt_q <= '0;
            pcnt_q <= '0;
            sum_q  <= '0;
        end else begin
            act_q <= act_o;
            if (act_o) begin
                if (wcnt_q != WW'(WIDE_LEN)) wcnt_q <= wcnt_q + WW'(1);
                if (pcnt_q < n_need) begin
                    sum_q  <= sum_q + AW'(pix_i);
                    pcnt_q <= pcnt_q + PW'(1);
                end
            end else begin
                wcnt_q <= '0;
                pcnt_q <= '0;
                sum_q  <= '0;
            end
        end
    end

    // R2: a line end is a single-clock event
    a_r2_single_end: assert property (@(posedge clk) disable iff (!rst_n)
        line_end_o |=> !line_end_o);
    // R3: never collects more pixels than the largest group
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= PW'(1 << AVG_LOG2));
    // R9: wide state only inside an ongoing window
    a_r9_wide_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        wide_o |-> act_q);
endmodule

// File: rtl/blc_err.sv
// Error former: subtracts the averaged or single pixel from the target,
// clamps the result and flags a large unclamped magnitude.
// Assumes ERR_MAX and THRESH fit in the signed error width.
module blc_err #(
    parameter int DW      = 12,
    parameter int AW      = 15,
    parameter int ERR_MAX = 255,
    parameter int THRESH  = 32,
    localparam int EW     = AW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        target_i,
    input  logic [DW-1:0]        pix_i,
    input  logic [AW-1:0]        avg_i,
    input  logic                 use_pix_i,
    output logic signed [EW-1:0] err_o,
    output logic                 big_o
);
    localparam logic signed [EW-1:0] ERR_P = EW'(ERR_MAX);
    localparam logic signed [EW-1:0] ERR_N = -ERR_P;
    localparam logic signed [EW-1:0] THR_P = EW'(THRESH);
    localparam logic signed [EW-1:0] THR_N = -THR_P;

    logic [AW-1:0]        src;
    logic signed [EW-1:0] raw;

    // Form the raw error, the clamp and the large-error flag
    always_comb begin
        src   = use_pix_i ? AW'(pix_i) : avg_i;
        raw   = $signed({1'b0, AW'(target_i)}) - $signed({1'b0, src});
        big_o = (raw > THR_P) || (raw < THR_N);
        if (raw > ERR_P)      err_o = ERR_P;
        else if (raw < ERR_N) err_o = ERR_N;
        else                  err_o = raw;
    end

    // R4: the clamped error stays inside its bound
    a_r4_clamp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o <= ERR_P) && (err_o >= ERR_N));
endmodule

// File: rtl/blc_acc.sv
// Correction accumulator: scales the clamped error by the normal or fast
// power-of-two gain and adds it with saturation.
// Assumes FRAC + FAST_BASE + 3 >= NORM_SHIFT so no step bits are lost early.
module blc_acc #(
    parameter int EW         = 16,
    parameter int ACC_W      = 22,
    parameter int FRAC       = 8,
    parameter int NORM_SHIFT = 8,
    parameter int FAST_BASE  = 2,
    parameter int FSEL_W     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_i,
    input  logic signed [EW-1:0]    err_i,
    input  logic                    fast_i,
    input  logic [FSEL_W-1:0]       fast_sel_i,
    output logic signed [ACC_W-1:0] acc_o
);
    localparam int FS_MAX = FAST_BASE + (1 << FSEL_W) - 1;
    localparam int SW     = EW + FRAC + FS_MAX;
    localparam int SUMW   = ((SW > ACC_W) ? SW : ACC_W) + 1;
    localparam int UW     = SUMW - ACC_W + 1;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [SW-1:0]   e_ext;
    logic signed [SW-1:0]   step;
    logic signed [SUMW-1:0] sum;
    logic [UW-1:0]          top;
    int unsigned            fs;

    // Scale the error and form the unsaturated next value
    always_comb begin
        fs    = fast_i ? (FAST_BASE + int'(fast_sel_i)) : 0;
        e_ext = {{(SW-EW){err_i[EW-1]}}, err_i};
        step  = (e_ext <<< (FRAC + fs)) >>> NORM_SHIFT;
        sum   = {{(SUMW-ACC_W){acc_o[ACC_W-1]}}, acc_o} + {{(SUMW-SW){step[SW-1]}}, step};
        top   = sum[SUMW-1:ACC_W-1];
    end

    // Register the accumulator, saturating at the signed range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (upd_i) begin
            if (top == '0 || top == '1) acc_o <= sum[ACC_W-1:0];
            else                        acc_o <= sum[SUMW-1] ? ACC_MIN : ACC_MAX;
        end
    end

    // R5: no update means the correction holds
    a_r5_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(acc_o));
endmodule

// File: rtl/blc_fast_ctl.sv
// Fast-acquisition controller: entered on a gain change, left after the
// selected number of consecutive small-error lines.
// Assumes gain_chg_i is a synchronous strobe.
module blc_fast_ctl
    import blc_pkg::*;
#(
    parameter int HOLD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gain_chg_i,
    input  logic              line_end_i,
    input  logic              line_upd_i,
    input  logic              avg_line_i,
    input  logic              upd_i,
    input  logic              big_i,
    input  logic [HOLD_W-1:0] hold_sel_i,
    output logic              fast_o
);
    blc_mode_e         mode_q;
    logic [HOLD_W-1:0] cnt_q;
    logic              big_q;
    logic              line_big;

    assign line_big = avg_line_i ? big_i : big_q;
    assign fast_o   = (mode_q == BLC_FAST);

    // Advance the mode and the small-error line count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= BLC_NORMAL;
            cnt_q  <= '0;
            big_q  <= 1'b0;
        end else begin
            if (upd_i) big_q <= big_i;
            if (gain_chg_i) begin
                mode_q <= BLC_FAST;
                cnt_q  <= '0;
            end else if (line_end_i && line_upd_i && mode_q == BLC_FAST) begin
                if (line_big) begin
                    cnt_q <= '0;
                end else if (cnt_q == hold_sel_i) begin
                    mode_q <= BLC_NORMAL;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + HOLD_W'(1);
                end
            end
        end
    end

    // R7: a gain change always yields fast mode
    a_r7_gain_forces_fast: assert property (@(posedge clk) disable iff (!rst_n)
        gain_chg_i |=> fast_o);
    // R8: fast mode only ends at a line end
    a_r8_exit_at_line_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_o) |-> $past(line_end_i));
endmodule

// File: rtl/blc_loop.sv
// Top of the black-level clamp loop: window front end, error former,
// fast-mode controller and correction accumulator.
// Assumes all inputs are synchronous to clk; corr_o is the integer part.
module blc_loop #(
    parameter int DW         = 12,
    parameter int AVG_LOG2   = 3,
    parameter int WIDE_LEN   = 63,
    parameter int ERR_MAX    = 255,
    parameter int THRESH     = 32,
    parameter int FRAC       = 8,
    parameter int NORM_SHIFT = 8,
    parameter int FAST_BASE  = 2,
    parameter int FSEL_W     = 2,
    parameter int HOLD_W     = 2,
    parameter int CW         = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_i,
    input  logic                 win_pol_i,
    input  logic [DW-1:0]        pix_i,
    input  logic                 gain_chg_i,
    input  logic [DW-1:0]        target_i,
    input  logic                 avg_sel_i,
    input  logic [FSEL_W-1:0]    fast_sel_i,
    input  logic [HOLD_W-1:0]    hold_sel_i,
    input  logic                 wide_en_i,
    output logic signed [CW-1:0] corr_o,
    output logic                 fast_o,
    output logic                 wide_o
);
    localparam int AW    = DW + AVG_LOG2;
    localparam int EW    = AW + 1;
    localparam int ACC_W = CW + FRAC;

    logic                    act, line_end, avg_rdy, big, upd, line_upd;
    logic [AW-1:0]           avg;
    logic signed [EW-1:0]    err;
    logic signed [ACC_W-1:0] acc;

    assign upd      = avg_rdy | (act & wide_o);
    assign line_upd = avg_rdy | wide_o;
    assign corr_o   = acc[ACC_W-1:FRAC];

    blc_window #(.DW(DW), .AVG_LOG2(AVG_LOG2), .WIDE_LEN(WIDE_LEN)) u_win (
        .clk(clk), .rst_n(rst_n), .win_i(win_i), .win_pol_i(win_pol_i),
        .pix_i(pix_i), .avg_sel_i(avg_sel_i), .wide_en_i(wide_en_i),
        .act_o(act), .line_end_o(line_end), .wide_o(wide_o),
        .avg_rdy_o(avg_rdy), .avg_o(avg)
    );

    blc_err #(.DW(DW), .AW(AW), .ERR_MAX(ERR_MAX), .THRESH(THRESH)) u_err (
        .clk(clk), .rst_n(rst_n), .target_i(target_i), .pix_i(pix_i),
        .avg_i(avg), .use_pix_i(wide_o), .err_o(err), .big_o(big)
    );

    blc_fast_ctl #(.HOLD_W(HOLD_W)) u_fast (
        .clk(clk), .rst_n(rst_n), .gain_chg_i(gain_chg_i), .line_end_i(line_end),
        .line_upd_i(line_upd), .avg_line_i(avg_rdy), .upd_i(upd), .big_i(big),
        .hold_sel_i(hold_sel_i), .fast_o(fast_o)
    );

    blc_acc #(.EW(EW), .ACC_W(ACC_W), .FRAC(FRAC), .NORM_SHIFT(NORM_SHIFT),
              .FAST_BASE(FAST_BASE), .FSEL_W(FSEL_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .err_i(err), .fast_i(fast_o),
        .fast_sel_i(fast_sel_i), .acc_o(acc)
    );

    // R9: wide state never appears while the feature is off
    a_r9_wide_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_en_i |-> !wide_o);
    // R1: the first edge after reset shows a cleared correction
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (corr_o == '0) && !fast_o);
endmodule

// File: tb/blc_loop_test.sv
`timescale 1ns/1ps
module blc_loop_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_i = 1'b0, win_pol_i = 1'b1, gain_chg_i = 1'b0;
    logic [11:0] pix_i = '0, target_i = '0;
    logic        avg_sel_i = 1'b0, wide_en_i = 1'b0;
    logic [1:0]  fast_sel_i = '0, hold_sel_i = '0;
    logic signed [13:0] corr_o;
    logic        fast_o, wide_o;

    blc_loop uut (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    // reference model state
    int     m_wcnt, m_pcnt, m_sum, m_cnt;
    longint m_acc;
    bit     m_act_q, m_fast, m_big;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint m_corr();
        return m_acc >>> 8;
    endfunction

    task automatic model_reset();
        m_wcnt = 0; m_pcnt = 0; m_sum = 0; m_cnt = 0;
        m_acc = 0; m_act_q = 0; m_fast = 0; m_big = 0;
    endtask

    task automatic model_step(input bit w_raw, input int p, input bit gc);
        bit act, wide, lend, avg_rdy, upd, big, b;
        int n, err, ec, fs;
        longint step, a;
        act = win_pol_i ? w_raw : !w_raw;
        wide = wide_en_i && (m_wcnt == 63);
        n = avg_sel_i ? 4 : 8;
        lend = m_act_q && !act;
        avg_rdy = lend && !wide && (m_pcnt == n);
        upd = 0; err = 0;
        if (act && wide) begin err = int'(target_i) - p; upd = 1; end
        else if (avg_rdy) begin err = int'(target_i) - (m_sum >> (avg_sel_i ? 2 : 3)); upd = 1; end
        big = (err > 32) || (err < -32);
        if (upd) begin
            ec = (err > 255) ? 255 : ((err < -255) ? -255 : err);
            fs = m_fast ? (2 + int'(fast_sel_i)) : 0;
            step = (longint'(ec) <<< (8 + fs)) >>> 8;
            a = m_acc + step;
            if (a > 2097151) a = 2097151;
            if (a < -2097152) a = -2097152;
            m_acc = a;
        end
        if (gc) begin m_fast = 1; m_cnt = 0; end
        else if (lend && m_fast && (avg_rdy || wide)) begin
            b = avg_rdy ? big : m_big;
            if (b) m_cnt = 0;
            else if (m_cnt == int'(hold_sel_i)) begin m_fast = 0; m_cnt = 0; end
            else m_cnt++;
        end
        if (upd) m_big = big;
        if (act) begin
            if (m_wcnt != 63) m_wcnt++;
            if (m_pcnt < n) begin m_sum += p; m_pcnt++; end
        end else begin
            m_wcnt = 0; m_pcnt = 0; m_sum = 0;
        end
        m_act_q = act;
    endtask

    // one clock: called just after a falling edge, returns after the next one
    task automatic tick(input bit active, input int p, input bit gc);
        bit raw;
        raw = win_pol_i ? active : !active;
        win_i = raw; pix_i = p[11:0]; gain_chg_i = gc;
        #1;
        chk({cur_tag, " corr_o"}, corr_o, m_corr());
        chk({cur_tag, " fast_o"}, fast_o, m_fast);
        chk({cur_tag, " wide_o"}, wide_o, wide_en_i && (m_wcnt == 63));
        model_step(raw, p, gc);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        win_i = win_pol_i ? 1'b0 : 1'b1; gain_chg_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic line(input int na, input int ni, input int px);
        for (int i = 0; i < na; i++) tick(1, px, 0);
        for (int i = 0; i < ni; i++) tick(0, px, 0);
    endtask

    function automatic int plant(input int base, input int noise);
        int v;
        v = base + noise + int'(corr_o);
        if (v < 0) v = 0;
        if (v > 4095) v = 4095;
        return v;
    endfunction

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_tag = "R1";
        do_reset();
        #1;
        chk("R1 corr_o after reset", corr_o, 0);
        chk("R1 fast_o after reset", fast_o, 0);
        chk("R1 wide_o after reset", wide_o, 0);

        // R6/R7: fast x32 step of an error of 100
        cur_tag = "R6";
        target_i = 200; fast_sel_i = 3; hold_sel_i = 0;
        tick(0, 0, 1);
        chk("R7 fast_o after gain change", fast_o, 1);
        line(8, 2, 100);
        chk("R6 corr_o fast x32", corr_o, 12);
        chk("R7 fast_o held by large error", fast_o, 1);

        // R5: normal gain, three lines of error 100
        cur_tag = "R5";
        do_reset();
        for (int k = 0; k < 3; k++) line(8, 2, 100);
        chk("R5 corr_o normal three lines", corr_o, 1);
        chk("R5 fast_o stays low", fast_o, 0);

        // R4: clamp to 255
        cur_tag = "R4";
        do_reset();
        target_i = 4000;
        tick(0, 0, 1);
        line(8, 2, 0);
        chk("R4 corr_o clamped step", corr_o, 31);

        // R3: average of 4 vs 8
        cur_tag = "R3";
        do_reset();
        target_i = 40; avg_sel_i = 1; hold_sel_i = 0;
        tick(0, 0, 1);
        for (int i = 0; i < 4; i++) tick(1, 40, 0);
        for (int i = 0; i < 4; i++) tick(1, 1000, 0);
        tick(0, 0, 0); tick(0, 0, 0);
        chk("R3 corr_o four-pixel average zero error", corr_o, 0);
        chk("R3 fast_o ends after small line", fast_o, 0);
        avg_sel_i = 0;
        for (int i = 0; i < 4; i++) tick(1, 40, 0);
        for (int i = 0; i < 4; i++) tick(1, 1000, 0);
        tick(0, 0, 0); tick(0, 0, 0);
        chk("R3 corr_o eight-pixel average", corr_o, -1);
        // R3: short window gives no update and keeps fast
        do_reset();
        target_i = 200;
        tick(0, 0, 1);
        line(5, 2, 100);
        chk("R3 corr_o short window", corr_o, 0);
        chk("R3 fast_o short window not counted", fast_o, 1);

        // R2: active-low window
        cur_tag = "R2";
        win_pol_i = 0;
        do_reset();
        target_i = 200; fast_sel_i = 3;
        tick(0, 0, 1);
        line(8, 2, 100);
        chk("R2 corr_o active-low window", corr_o, 12);
        win_pol_i = 1;

        // R8: hold lines = hold_sel + 1
        cur_tag = "R8";
        win_pol_i = 1;
        do_reset();
        target_i = 100; fast_sel_i = 0; hold_sel_i = 2;
        tick(0, 0, 1);
        line(8, 2, 100); line(8, 2, 100);
        chk("R8 fast_o after two small lines", fast_o, 1);
        line(8, 2, 100);
        chk("R8 fast_o after three small lines", fast_o, 0);
        tick(0, 0, 1);
        line(8, 2, 100); line(8, 2, 0);
        line(8, 2, 100); line(8, 2, 100);
        chk("R8 fast_o after restart by large error", fast_o, 1);
        line(8, 2, 100);
        chk("R8 fast_o exit after restart", fast_o, 0);

        // R9/R10: wide window with per-clock updates
        cur_tag = "R9";
        do_reset();
        target_i = 100; fast_sel_i = 3; hold_sel_i = 0; wide_en_i = 1;
        tick(0, 0, 1);
        for (int i = 0; i < 63; i++) tick(1, 90, 0);
        chk("R9 wide_o after 63 active clocks", wide_o, 1);
        for (int i = 0; i < 7; i++) tick(1, 90, 0);
        tick(0, 90, 0); tick(0, 90, 0);
        chk("R9 corr_o seven per-clock steps", corr_o, 8);
        chk("R10 fast_o from last per-clock error", fast_o, 0);

        // R11: wide disabled
        cur_tag = "R11";
        do_reset();
        wide_en_i = 0;
        tick(0, 0, 1);
        for (int i = 0; i < 70; i++) tick(1, 90, 0);
        chk("R11 wide_o stays low", wide_o, 0);
        tick(0, 90, 0); tick(0, 90, 0);
        chk("R11 corr_o single averaged step", corr_o, 1);

        // R5: saturation
        cur_tag = "R5";
        do_reset();
        target_i = 4095; fast_sel_i = 3;
        tick(0, 0, 1);
        for (int k = 0; k < 300; k++) line(8, 2, 0);
        chk("R5 corr_o saturated", corr_o, 8191);

        // R10: constrained random with a plant closing the loop
        cur_tag = "R10";
        void'($urandom(32'h5eed_1234));
        do_reset();
        begin
            int base;
            base = 500;
            for (int ln = 0; ln < 1500; ln++) begin
                int na, ni, r, gc_at;
                if (ln % 50 == 0) begin
                    win_pol_i  = $urandom_range(0, 1);
                    avg_sel_i  = $urandom_range(0, 1);
                    wide_en_i  = $urandom_range(0, 1);
                    fast_sel_i = $urandom_range(0, 3);
                    hold_sel_i = $urandom_range(0, 3);
                    target_i   = 12'($urandom_range(1000, 3000));
                    base       = $urandom_range(0, 4000);
                end
                r = $urandom_range(0, 99);
                if (r < 50) na = $urandom_range(1, 12);
                else if (r < 85) na = $urandom_range(12, 60);
                else na = $urandom_range(60, 80);
                ni = $urandom_range(1, 5);
                gc_at = ($urandom_range(0, 99) < 4) ? $urandom_range(0, na - 1) : -1;
                for (int i = 0; i < na; i++)
                    tick(1, plant(base, $urandom_range(0, 15)), (i == gc_at));
                for (int i = 0; i < ni; i++)
                    tick(0, plant(base, $urandom_range(0, 15)), 0);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule